// File: doc/BRIEF.md
# Configurable Edge and Level Interrupt Bank

This block watches a group of input lines, eight by default, and raises a single interrupt request when any enabled line shows the event it was set up for. Each line is configured on its own to trigger on a rising edge, a falling edge, either edge, a high level or a low level. Three per-line control bits select the trigger:

- a mode bit picks level or edge;
- a both-edge bit makes any transition count;
- a polarity bit picks high/rising or low/falling.

Software reads a sticky raw status word and a masked status word. It acknowledges a line by writing 1 to that line's bit in the clear register. It can also read back the sampled level of every line.

One RTL covers two variants, selected by a parameter. In the system-clock variant the lines are synchronised and sampled on every clock cycle, much like a general-purpose input port. In the slow-clock variant a separate slow clock, nominally 32 kHz, is first synchronised into the system domain. Its rising edges then act as the sample instants. A pulse that begins and ends between two slow edges is therefore not seen.

The register port is a plain single-cycle write strobe with a combinational read. Reads have no side effects.

Top module: `edge_level_irq_bank`

## Requirements
- R1: After reset every register reads 0 and irq_o is 0.
- R2: Enable (byte address 0x00), mode (0x10), both-edge (0x14) and polarity (0x18) are read/write. Bit n controls line n. Bits above the line count read as 0.
- R3: With mode=0 and both-edge=0, polarity 1 sets raw status (0x04) bit n on a rising edge of line n only, and polarity 0 on a falling edge only. The bit then stays set until cleared.
- R4: With mode=0 and both-edge=1, either transition of line n sets raw bit n, whatever the polarity bit holds.
- R5: With mode=1, raw bit n is set in every cycle in which line n sits at its active level (high when polarity=1, low when polarity=0). The both-edge bit has no effect in this mode. A clear while the level is still active leaves the bit set. Once the level has gone, the bit stays set until cleared.
- R6: Writing the clear register (0x0C) clears each raw bit written as 1 and leaves bits written as 0 untouched. The clear register reads 0.
- R7: Masked status (0x08) equals raw status AND enable. irq_o is the OR of the masked bits.
- R8: Input data (0x1C) shows the latest sampled level of each line. Writes to 0x04, 0x08 and 0x1C are ignored.
- R9: In the system-clock variant, data bit n changes on the third rising clock edge after line n changes. An edge sets raw bit n on the fourth.
- R10: In the slow-clock variant, lines are sampled only at synchronised rising edges of slow_clk, so a pulse lying wholly between two slow edges is not reported.
- R11: An event on one line sets only that line's raw bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk | input | 1 | Slow sample clock, used by the slow-clock variant only |
| pin_i | input | NCH | Monitored input lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
Every line is swept through all eight mode/both-edge/polarity combinations, once with a rising and once with a falling transition. Each case is read before and after an acknowledge. This separates a sticky edge event from a held level, and it separates a level that is still active from one that has ended. The enable pattern alternates between only the active line and every other line, which shows that masking acts per bit. Two further stimuli check timing: a single transition timed edge by edge fixes the synchroniser latency, and a short pulse placed between slow-clock edges, compared with a level held across one, shows that the slow variant samples only at its own instants.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

  // Register select, taken from byte address bits [4:2].
  typedef enum logic [2:0] {
    SEL_EN   = 3'd0,
    SEL_RAW  = 3'd1,
    SEL_MSK  = 3'd2,
    SEL_CLR  = 3'd3,
    SEL_MODE = 3'd4,
    SEL_BOTH = 3'd5,
    SEL_POL  = 3'd6,
    SEL_DATA = 3'd7
  } reg_sel_e;

  localparam int unsigned SEL_LSB = 2;
  localparam int unsigned MAP_BITS = 5;

endpackage

// File: rtl/irqb_sampler.sv
module irqb_sampler #(
  parameter int NCH      = 8,
  parameter bit USE_SLOW = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           slow_clk,
  input  logic [NCH-1:0] pin_i,
  output logic [NCH-1:0] cur_o,
  output logic [NCH-1:0] prev_o,
  output logic           fresh_o
);

  logic [NCH-1:0] meta_q, sync_q;
  logic [2:0]     slow_q;
  logic           strobe;

  // Two-flop synchronisers for the lines and for the slow clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      slow_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      slow_q <= {slow_q[1:0], slow_clk};
    end
  end

  // Sample instant: every cycle, or a synchronised slow rising edge.
  always_comb begin
    strobe = USE_SLOW ? (slow_q[1] & ~slow_q[2]) : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_o   <= '0;
      prev_o  <= '0;
      fresh_o <= 1'b0;
    end else begin
      fresh_o <= strobe;
      if (strobe) begin
        cur_o  <= sync_q;
        prev_o <= cur_o;
      end
    end
  end

  // R10: the history only moves at a sample instant.
  a_r10_history_moves_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !fresh_o |-> (cur_o == $past(cur_o)) || $past(fresh_o) || $past(!rst_n));

endmodule

// File: rtl/irqb_detect.sv
module irqb_detect #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cur_i,
  input  logic [NCH-1:0] prev_i,
  input  logic           fresh_i,
  input  logic [NCH-1:0] mode_i,
  input  logic [NCH-1:0] both_i,
  input  logic [NCH-1:0] pol_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] raw_o
);

  for (genvar g = 0; g < NCH; g++) begin : g_line
    logic rise, fall, edge_hit, level_hit, set_now;

    always_comb begin
      rise      = cur_i[g] & ~prev_i[g];
      fall      = ~cur_i[g] & prev_i[g];
      edge_hit  = fresh_i & ~mode_i[g] &
                  (both_i[g] ? (rise | fall) : (pol_i[g] ? rise : fall));
      level_hit = mode_i[g] & ~(cur_i[g] ^ pol_i[g]);
      set_now   = edge_hit | level_hit;
    end

    // A new event wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         raw_o[g] <= 1'b0;
      else if (set_now)   raw_o[g] <= 1'b1;
      else if (clr_i[g])  raw_o[g] <= 1'b0;
    end

    // R6: a set bit survives until a clear is written.
    a_r6_sticky_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
      raw_o[g] && !clr_i[g] |=> raw_o[g]);

    // R4: any transition in both-edge mode sets the bit.
    a_r4_both_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      fresh_i && !mode_i[g] && both_i[g] && (cur_i[g] != prev_i[g]) |=> raw_o[g]);

    // R5: an active level keeps the bit set.
    a_r5_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
      mode_i[g] && (cur_i[g] == pol_i[g]) |=> raw_o[g]);

    // R3: in edge mode nothing new appears without a fresh sample.
    a_r3_no_edge_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
      !raw_o[g] && !fresh_i && !mode_i[g] |=> !raw_o[g]);
  end

endmodule

// File: rtl/irqb_regs.sv
module irqb_regs
  import irqb_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 5,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  input  logic [NCH-1:0] raw_i,
  input  logic [NCH-1:0] data_i,
  output logic [NCH-1:0] mode_o,
  output logic [NCH-1:0] both_o,
  output logic [NCH-1:0] pol_o,
  output logic [NCH-1:0] clr_o,
  output logic           irq_o
);

  logic [NCH-1:0] en_q, masked;
  reg_sel_e       sel;
  logic           in_map, wr_hit;

  always_comb begin
    sel    = reg_sel_e'(addr_i[SEL_LSB +: 3]);
    in_map = (addr_i[1:0] == 2'b00) && ((addr_i >> MAP_BITS) == '0);
    wr_hit = wr_i & in_map;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_o <= '0;
      both_o <= '0;
      pol_o  <= '0;
    end else if (wr_hit) begin
      case (sel)
        SEL_EN:   en_q   <= wdata_i[NCH-1:0];
        SEL_MODE: mode_o <= wdata_i[NCH-1:0];
        SEL_BOTH: both_o <= wdata_i[NCH-1:0];
        SEL_POL:  pol_o  <= wdata_i[NCH-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    clr_o  = (wr_hit && sel == SEL_CLR) ? wdata_i[NCH-1:0] : '0;
    masked = raw_i & en_q;
    irq_o  = |masked;
  end

  always_comb begin
    rdata_o = '0;
    if (in_map) begin
      case (sel)
        SEL_EN:   rdata_o[NCH-1:0] = en_q;
        SEL_RAW:  rdata_o[NCH-1:0] = raw_i;
        SEL_MSK:  rdata_o[NCH-1:0] = masked;
        SEL_MODE: rdata_o[NCH-1:0] = mode_o;
        SEL_BOTH: rdata_o[NCH-1:0] = both_o;
        SEL_POL:  rdata_o[NCH-1:0] = pol_o;
        SEL_DATA: rdata_o[NCH-1:0] = data_i;
        default:  rdata_o = '0;
      endcase
    end
  end

  if (DW > NCH) begin : g_spare
    logic unused_wbits;
    assign unused_wbits = ^wdata_i[DW-1:NCH];
  end

  // R7: a request needs at least one enabled line.
  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_q != '0));

  // R6: the clear register never reads back a value.
  a_r6_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_map && sel == SEL_CLR) |-> (rdata_o == '0));

endmodule

// File: rtl/edge_level_irq_bank.sv
module edge_level_irq_bank #(
  parameter int NCH      = 8,
  parameter int AW       = 5,
  parameter int DW       = 32,
  parameter bit USE_SLOW = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           slow_clk,
  input  logic [NCH-1:0] pin_i,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           irq_o
);

  logic [NCH-1:0] cur, prev, mode, both, pol, clr, raw;
  logic           fresh;

  irqb_sampler #(.NCH(NCH), .USE_SLOW(USE_SLOW)) u_sampler (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .pin_i(pin_i),
    .cur_o(cur), .prev_o(prev), .fresh_o(fresh)
  );

  irqb_detect #(.NCH(NCH)) u_detect (
    .clk(clk), .rst_n(rst_n), .cur_i(cur), .prev_i(prev), .fresh_i(fresh),
    .mode_i(mode), .both_i(both), .pol_i(pol), .clr_i(clr), .raw_o(raw)
  );

  irqb_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .raw_i(raw), .data_i(cur),
    .mode_o(mode), .both_o(both), .pol_o(pol), .clr_o(clr), .irq_o(irq_o)
  );

endmodule

// File: tb/edge_level_irq_bank_test.sv
module edge_level_irq_bank_test;

  localparam logic [4:0] A_EN = 5'h00, A_RAW = 5'h04, A_MSK = 5'h08, A_CLR = 5'h0C,
                         A_MODE = 5'h10, A_BOTH = 5'h14, A_POL = 5'h18, A_DATA = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic [7:0]  pins = '0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, s_rdata;
  logic        irq, s_irq;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  edge_level_irq_bank #(.USE_SLOW(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .pin_i(pins), .reg_wr(wr),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq));

  edge_level_irq_bank #(.USE_SLOW(1'b1)) uut_slow (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .pin_i(pins), .reg_wr(wr),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(s_rdata), .irq_o(s_irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, output logic [31:0] ds);
    addr = a;
    #1;
    d = rdata;
    ds = s_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, vs;
    idle(2);
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(5'(a * 4), v, vs);
      chk("R1 reset register", v, 32'h0);
    end
    chk("R1 reset irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    idle(2);

    // R2: read/write control registers
    wr_reg(A_EN, 32'hFFFF_FFA5); rd(A_EN, v, vs);   chk("R2 enable", v, 32'hA5);
    wr_reg(A_MODE, 32'h3C);      rd(A_MODE, v, vs); chk("R2 mode", v, 32'h3C);
    wr_reg(A_BOTH, 32'h5A);      rd(A_BOTH, v, vs); chk("R2 both-edge", v, 32'h5A);
    wr_reg(A_POL, 32'hC3);       rd(A_POL, v, vs);  chk("R2 polarity", v, 32'hC3);
    rd(A_CLR, v, vs);            chk("R6 clear reads zero", v, 32'h0);

    // R8: read-only registers ignore writes (quiet config: falling edge, pins low)
    wr_reg(A_MODE, 0); wr_reg(A_BOTH, 0); wr_reg(A_POL, 0);
    wr_reg(A_CLR, 32'hFF);
    idle(2);
    wr_reg(A_RAW, 32'hFF);  rd(A_RAW, v, vs);  chk("R8 raw write ignored", v, 32'h0);
    wr_reg(A_MSK, 32'hFF);  rd(A_MSK, v, vs);  chk("R8 masked write ignored", v, 32'h0);
    wr_reg(A_DATA, 32'hFF); rd(A_DATA, v, vs); chk("R8 data write ignored", v, 32'h0);

    // R9: latency of a rising edge on line 3
    wr_reg(A_POL, 32'hFF);
    idle(2);
    @(negedge clk); pins[3] = 1'b1;
    idle(3);
    rd(A_RAW, v, vs);  chk("R9 raw not yet set after 3 edges", v, 32'h0);
    rd(A_DATA, v, vs); chk("R9 data after 3 edges", v, 32'h08);
    idle(1);
    rd(A_RAW, v, vs);  chk("R9 raw set after 4 edges", v, 32'h08);

    // R6: partial clear leaves other lines set
    pins = '0;
    wr_reg(A_BOTH, 32'h42);
    wr_reg(A_CLR, 32'hFF);
    idle(6);
    pins[1] = 1'b1; pins[6] = 1'b1;
    idle(6);
    wr_reg(A_CLR, 32'h02);
    rd(A_RAW, v, vs); chk("R6 partial clear", v, 32'h40);

    // R3 R4 R5 R7 R8 R11: sweep of lines, trigger settings and transitions
    for (int ch = 0; ch < 8; ch++) begin
      for (int cfg = 0; cfg < 8; cfg++) begin
        for (int init = 0; init < 2; init++) begin
          logic [7:0] bitv;
          logic m, b, p, fin, ea, eb, ena;
          string tag;
          bitv = 8'(1 << ch);
          m = cfg[2]; b = cfg[1]; p = cfg[0];
          fin = (init == 0);
          ea = m ? 1'b1 : (b ? 1'b1 : (p ? fin : ~fin));
          eb = m ? (p == fin) : 1'b0;
          ena = p;
          tag = m ? "R5 R11 level" : (b ? "R4 R11 both-edge" : "R3 R11 single edge");
          pins = '0;
          wr_reg(A_MODE, {24'b0, m ? bitv : 8'h00});
          wr_reg(A_BOTH, {24'b0, b ? bitv : 8'h00});
          wr_reg(A_POL,  {24'b0, p ? 8'hFF : ~bitv});
          wr_reg(A_EN,   {24'b0, ena ? bitv : ~bitv});
          idle(1);
          pins[ch] = (init != 0);
          idle(6);
          wr_reg(A_CLR, 32'hFF);
          idle(2);
          pins[ch] = fin;
          idle(6);
          rd(A_RAW, v, vs);  chk(tag, v, {24'b0, ea ? bitv : 8'h00});
          rd(A_MSK, v, vs);  chk("R7 masked", v, {24'b0, (ea && ena) ? bitv : 8'h00});
          chk("R7 irq", {31'b0, irq}, {31'b0, ea & ena});
          rd(A_DATA, v, vs); chk("R8 data", v, {24'b0, fin ? bitv : 8'h00});
          wr_reg(A_CLR, 32'hFF);
          idle(1);
          rd(A_RAW, v, vs);
          chk(m ? "R5 after clear" : "R6 after clear", v, {24'b0, eb ? bitv : 8'h00});
        end
      end
    end

    // R10: slow-clock variant samples only at slow edges
    pins = '0;
    wr_reg(A_MODE, 0); wr_reg(A_POL, 0); wr_reg(A_BOTH, 32'h01); wr_reg(A_EN, 32'h01);
    wr_reg(A_CLR, 32'hFF);
    idle(2);
    rd(A_RAW, v, vs); chk("R10 slow baseline", vs, 32'h0);
    pins[0] = 1'b1; idle(3); pins[0] = 1'b0;
    idle(10);
    rd(A_RAW, v, vs); chk("R10 pulse between slow edges missed", vs, 32'h0);
    chk("R10 slow irq quiet", {31'b0, s_irq}, 32'h0);
    pins[0] = 1'b1;
    idle(4);
    slow_clk = 1'b1;
    idle(8);
    rd(A_RAW, v, vs);  chk("R10 held level seen at slow edge", vs, 32'h01);
    rd(A_DATA, v, vs); chk("R10 slow data", vs, 32'h01);
    chk("R10 slow irq", {31'b0, s_irq}, 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule